// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general registers of a processor core that runs in several privilege modes. Registers 0–7 and the program counter (register 15) are shared by every mode. Registers 8–12 have a second copy that is used only while the core is in the fast-interrupt mode. The stack pointer and link register (registers 13 and 14) have one copy per mode group. User and System form one group, and each exception mode has its own. Each exception mode also keeps its own saved status word.

The core reads through two combinational read ports and writes through one synchronous write port. All three resolve against the current mode. A separate user-bank port always reaches the User/System copies, whatever the current mode. Block transfers from privileged code use it. A mode change request moves the mode field of the status word in one clock. Because every banked copy has its own physical storage, no copying cycle is needed. A boot strobe loads a fixed set of start-up values so the core can skip a boot program.

Top module: `rbank_top`

## Requirements
- R1: After reset the status word is 0x00000013 (Supervisor), every register reads 0 in every mode, and every saved status word is 0.
- R2: Mode encodings are User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. A change request with a known encoding sets status bits [4:0] at the next clock edge. From that cycle on, reads resolve against the new mode.
- R3: A change request with any other encoding pulses modeErr high for the one cycle after the edge. The status word and all register contents stay unchanged.
- R4: Registers 13 and 14 have six copies: User/System, Supervisor, Abort, Undefined, IRQ and FIQ. A live access reaches the copy of the current mode's group.
- R5: Registers 8–12 have two copies. FIQ mode uses one of them and every other mode uses the other.
- R6: Registers 0–7 and 15 are a single copy shared by all modes.
- R7: Each of the five exception modes has its own saved status word, written with spsrWe and read on spsrRData. In User or System mode a saved-status write is ignored and spsrRData reads 0. In those modes spsrIllegal follows spsrRdEn in the same cycle.
- R8: The user-bank port reaches the non-FIQ copy of registers 8–12 and the User/System copy of registers 13–14 in every mode. All other indices reach the shared register.
- R9: A boot strobe sets the following at the next edge. r0 = 0x08000000, r1 = 0x000000EA, User/System r13 = 0x03007F00, r15 = 0x08000000, IRQ r13 = 0x03007FA0 and Supervisor r13 = 0x03007FE0. Every other register copy and every saved status word is cleared. The status word becomes 0x6000001F.
- R10: A write in the same cycle as a mode change lands in the outgoing mode's copy. When a user-bank write and a live write hit the same storage, the user-bank write wins. A boot strobe overrides both writes and the mode change.
- R11: Both read ports and the user-bank read are combinational. Each returns the addressed register in the same cycle the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bootReq | input | 1 | Load boot preset values |
| modeChgReq | input | 1 | Request a mode change to modeIn |
| modeIn | input | 5 | Requested mode encoding |
| rdAddrA | input | 4 | Read port A index |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B index |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Live write enable |
| wrAddr | input | 4 | Live write index |
| wrData | input | 32 | Live write data |
| usrAddr | input | 4 | User-bank index |
| usrWe | input | 1 | User-bank write enable |
| usrWData | input | 32 | User-bank write data |
| usrRData | output | 32 | User-bank read data |
| spsrRdEn | input | 1 | Saved-status read strobe |
| spsrWe | input | 1 | Saved-status write enable |
| spsrWData | input | 32 | Saved-status write data |
| spsrRData | output | 32 | Saved status of current mode |
| spsrIllegal | output | 1 | Saved-status read in User/System |
| statusOut | output | 32 | Status word, mode in bits [4:0] |
| modeErr | output | 1 | Unknown mode requested last cycle |

## Verification
Read data and spsrIllegal are combinational, so the bench samples them a fraction of a nanosecond after it sets an address. No clock edge passes between setting an address and sampling the result. Writes, mode changes and boot presets pass through one register stage. The bench drives them just after a rising edge and samples one nanosecond after the following edge. modeErr is registered in the same way, so it is checked in that cycle and is expected low again one cycle later. Every register copy in every mode is swept against a bench model kept purely from the banking rules.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

  localparam int NUM_GRP   = 6;
  localparam int NUM_SAVED = NUM_GRP - 1;
  localparam int GRP_W     = $clog2(NUM_GRP);

  localparam int GRP_USR = 0;
  localparam int GRP_SVC = 1;
  localparam int GRP_ABT = 2;
  localparam int GRP_UND = 3;
  localparam int GRP_IRQ = 4;
  localparam int GRP_FIQ = 5;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  localparam logic [31:0] RST_STATUS  = 32'h0000_0013;
  localparam logic [31:0] BOOT_STATUS = 32'h6000_001F;
  localparam logic [31:0] BOOT_R0     = 32'h0800_0000;
  localparam logic [31:0] BOOT_R1     = 32'h0000_00EA;
  localparam logic [31:0] BOOT_SP_USR = 32'h0300_7F00;
  localparam logic [31:0] BOOT_SP_IRQ = 32'h0300_7FA0;
  localparam logic [31:0] BOOT_SP_SVC = 32'h0300_7FE0;
  localparam logic [31:0] BOOT_PC     = 32'h0800_0000;

  // Strobes from control to datapath
  typedef struct packed {
    logic             boot;
    logic             liveWe;
    logic             usrWe;
    logic             spsrWe;
    logic             fiqSel;
    logic             hasSaved;
    logic [GRP_W-1:0] grp;
  } ctrl_s;

  function automatic logic modeKnown(input logic [4:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic [GRP_W-1:0] grpOf(input logic [4:0] m);
    case (m)
      MODE_SVC: return GRP_W'(GRP_SVC);
      MODE_ABT: return GRP_W'(GRP_ABT);
      MODE_UND: return GRP_W'(GRP_UND);
      MODE_IRQ: return GRP_W'(GRP_IRQ);
      MODE_FIQ: return GRP_W'(GRP_FIQ);
      default:  return GRP_W'(GRP_USR);
    endcase
  endfunction

endpackage

// File: rtl/rbank_ctrl.sv
module rbank_ctrl
  import rbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bootReq,
  input  logic          modeChgReq,
  input  logic [4:0]    modeIn,
  input  logic          wrEn,
  input  logic          usrWe,
  input  logic          spsrWe,
  input  logic          spsrRdEn,
  output ctrl_s         ctl,
  output logic [DW-1:0] statusOut,
  output logic          modeErr,
  output logic          spsrIllegal
);

  logic [DW-1:0] statusReg;
  logic          modeErrQ;
  logic [4:0]    curMode;
  logic          reqValid;
  logic          saved;

  assign curMode  = statusReg[4:0];
  assign reqValid = modeKnown(modeIn);
  assign saved    = (grpOf(curMode) != GRP_W'(GRP_USR));

  always_comb begin
    ctl          = '0;
    ctl.boot     = bootReq;
    ctl.liveWe   = wrEn & ~bootReq;
    ctl.usrWe    = usrWe & ~bootReq;
    ctl.spsrWe   = spsrWe & saved & ~bootReq;
    ctl.fiqSel   = (curMode == MODE_FIQ);
    ctl.hasSaved = saved;
    ctl.grp      = grpOf(curMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= DW'(RST_STATUS);
      modeErrQ  <= 1'b0;
    end else begin
      modeErrQ <= modeChgReq & ~reqValid & ~bootReq;
      if (bootReq)
        statusReg <= DW'(BOOT_STATUS);
      else if (modeChgReq && reqValid)
        statusReg[4:0] <= modeIn;
    end
  end

  assign statusOut   = statusReg;
  assign modeErr     = modeErrQ;
  assign spsrIllegal = spsrRdEn & ~saved;

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeKnown(statusReg[4:0]));

  p_mode_switch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeChgReq && modeKnown(modeIn) && !bootReq) |=> (statusReg[4:0] == $past(modeIn)));

  p_bad_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeChgReq && !modeKnown(modeIn) && !bootReq) |=> (modeErr && $stable(statusReg)));

  p_boot_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    bootReq |=> (statusReg == DW'(BOOT_STATUS)));

endmodule

// File: rtl/rbank_dp.sv
module rbank_dp
  import rbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_s         ctl,
  input  logic [3:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [3:0]    usrAddr,
  input  logic [DW-1:0] usrWData,
  input  logic [3:0]    rdAddrA,
  input  logic [3:0]    rdAddrB,
  input  logic [DW-1:0] spsrWData,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  output logic [DW-1:0] usrRData,
  output logic [DW-1:0] spsrRData
);

  localparam int AW     = 4;
  localparam int LOW_N  = 8;
  localparam int HI_N   = 5;
  localparam int LOW_W  = $clog2(LOW_N);
  localparam int HI_W   = $clog2(HI_N);
  localparam int SP_IDX = LOW_N + HI_N;
  localparam int LR_IDX = SP_IDX + 1;

  // storage
  logic [DW-1:0]                       lowQ [LOW_N];
  logic [1:0][HI_N-1:0][DW-1:0]        hiQ;
  logic [DW-1:0]                       spQ  [NUM_GRP];
  logic [DW-1:0]                       lrQ  [NUM_GRP];
  logic [DW-1:0]                       pcQ;
  logic [NUM_SAVED-1:0][DW-1:0]        savedQ;

  // write enables
  logic [LOW_N-1:0]            lowWeL, lowWeU;
  logic [1:0][HI_N-1:0]        hiWeL, hiWeU;
  logic [NUM_GRP-1:0]          spWeL, spWeU, lrWeL, lrWeU;
  logic                        pcWeL, pcWeU;
  logic [NUM_SAVED-1:0]        savedWe;

  for (genvar i = 0; i < LOW_N; i++) begin : g_low
    assign lowWeL[i] = ctl.liveWe && (wrAddr == AW'(i));
    assign lowWeU[i] = ctl.usrWe && (usrAddr == AW'(i));
  end

  for (genvar c = 0; c < 2; c++) begin : g_hiCopy
    for (genvar j = 0; j < HI_N; j++) begin : g_hiReg
      assign hiWeL[c][j] = ctl.liveWe && (wrAddr == AW'(LOW_N + j))
                           && (ctl.fiqSel == (c == 1));
      assign hiWeU[c][j] = (c == 0) && ctl.usrWe && (usrAddr == AW'(LOW_N + j));
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign spWeL[g] = ctl.liveWe && (wrAddr == AW'(SP_IDX)) && (ctl.grp == GRP_W'(g));
    assign lrWeL[g] = ctl.liveWe && (wrAddr == AW'(LR_IDX)) && (ctl.grp == GRP_W'(g));
    assign spWeU[g] = (g == GRP_USR) && ctl.usrWe && (usrAddr == AW'(SP_IDX));
    assign lrWeU[g] = (g == GRP_USR) && ctl.usrWe && (usrAddr == AW'(LR_IDX));
  end

  for (genvar k = 0; k < NUM_SAVED; k++) begin : g_saved
    assign savedWe[k] = ctl.spsrWe && (ctl.grp == GRP_W'(k + 1));
  end

  assign pcWeL = ctl.liveWe && (wrAddr == 4'hF);
  assign pcWeU = ctl.usrWe && (usrAddr == 4'hF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LOW_N; i++) lowQ[i] <= '0;
      for (int g = 0; g < NUM_GRP; g++) begin
        spQ[g] <= '0;
        lrQ[g] <= '0;
      end
      hiQ    <= '0;
      pcQ    <= '0;
      savedQ <= '0;
    end else if (ctl.boot) begin
      for (int i = 0; i < LOW_N; i++)
        lowQ[i] <= (i == 0) ? DW'(BOOT_R0) : (i == 1) ? DW'(BOOT_R1) : '0;
      for (int g = 0; g < NUM_GRP; g++) begin
        spQ[g] <= (g == GRP_USR) ? DW'(BOOT_SP_USR) :
                  (g == GRP_IRQ) ? DW'(BOOT_SP_IRQ) :
                  (g == GRP_SVC) ? DW'(BOOT_SP_SVC) : '0;
        lrQ[g] <= '0;
      end
      hiQ    <= '0;
      pcQ    <= DW'(BOOT_PC);
      savedQ <= '0;
    end else begin
      for (int i = 0; i < LOW_N; i++) begin
        if (lowWeU[i])      lowQ[i] <= usrWData;
        else if (lowWeL[i]) lowQ[i] <= wrData;
      end
      for (int c = 0; c < 2; c++) begin
        for (int j = 0; j < HI_N; j++) begin
          if (hiWeU[c][j])      hiQ[c][j] <= usrWData;
          else if (hiWeL[c][j]) hiQ[c][j] <= wrData;
        end
      end
      for (int g = 0; g < NUM_GRP; g++) begin
        if (spWeU[g])      spQ[g] <= usrWData;
        else if (spWeL[g]) spQ[g] <= wrData;
        if (lrWeU[g])      lrQ[g] <= usrWData;
        else if (lrWeL[g]) lrQ[g] <= wrData;
      end
      if (pcWeU)      pcQ <= usrWData;
      else if (pcWeL) pcQ <= wrData;
      for (int k = 0; k < NUM_SAVED; k++)
        if (savedWe[k]) savedQ[k] <= spsrWData;
    end
  end

  function automatic logic [DW-1:0] pick(input logic [AW-1:0] a,
                                         input logic f,
                                         input logic [GRP_W-1:0] g);
    logic [DW-1:0] v;
    logic [HI_W-1:0] hiIdx;
    hiIdx = HI_W'(a - AW'(LOW_N));
    if (a < AW'(LOW_N))        v = lowQ[a[LOW_W-1:0]];
    else if (a < AW'(SP_IDX))  v = hiQ[f][hiIdx];
    else if (a == AW'(SP_IDX)) v = spQ[g];
    else if (a == AW'(LR_IDX)) v = lrQ[g];
    else                       v = pcQ;
    return v;
  endfunction

  always_comb begin
    rdDataA   = pick(rdAddrA, ctl.fiqSel, ctl.grp);
    rdDataB   = pick(rdAddrB, ctl.fiqSel, ctl.grp);
    usrRData  = pick(usrAddr, 1'b0, GRP_W'(GRP_USR));
    spsrRData = ctl.hasSaved ? savedQ[ctl.grp - GRP_W'(1)] : '0;
  end

  p_fiq_hi_isolated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.liveWe && !ctl.usrWe && ctl.fiqSel && !ctl.boot) |=> $stable(hiQ[0]));

  p_saved_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.spsrWe && !ctl.boot) |=> $stable(savedQ));

  p_usr_sp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.usrWe && usrAddr == AW'(SP_IDX)) |=> (spQ[GRP_USR] == $past(usrWData)));

  p_boot_pc_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.boot |=> (pcQ == DW'(BOOT_PC)));

endmodule

// File: rtl/rbank_top.sv
module rbank_top
  import rbank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bootReq,
  input  logic        modeChgReq,
  input  logic [4:0]  modeIn,
  input  logic [3:0]  rdAddrA,
  output logic [31:0] rdDataA,
  input  logic [3:0]  rdAddrB,
  output logic [31:0] rdDataB,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [3:0]  usrAddr,
  input  logic        usrWe,
  input  logic [31:0] usrWData,
  output logic [31:0] usrRData,
  input  logic        spsrRdEn,
  input  logic        spsrWe,
  input  logic [31:0] spsrWData,
  output logic [31:0] spsrRData,
  output logic        spsrIllegal,
  output logic [31:0] statusOut,
  output logic        modeErr
);

  localparam int DW = 32;

  ctrl_s ctl;

  rbank_ctrl #(.DW(DW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bootReq     (bootReq),
    .modeChgReq  (modeChgReq),
    .modeIn      (modeIn),
    .wrEn        (wrEn),
    .usrWe       (usrWe),
    .spsrWe      (spsrWe),
    .spsrRdEn    (spsrRdEn),
    .ctl         (ctl),
    .statusOut   (statusOut),
    .modeErr     (modeErr),
    .spsrIllegal (spsrIllegal)
  );

  rbank_dp #(.DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .usrAddr   (usrAddr),
    .usrWData  (usrWData),
    .rdAddrA   (rdAddrA),
    .rdAddrB   (rdAddrB),
    .spsrWData (spsrWData),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB),
    .usrRData  (usrRData),
    .spsrRData (spsrRData)
  );

endmodule

// File: tb/rbank_top_tb.sv
`timescale 1ns/1ps
module rbank_top_tb;

  logic        clk = 1'b0;
  logic        rstN, bootReq, modeChgReq, wrEn, usrWe, spsrRdEn, spsrWe;
  logic [4:0]  modeIn;
  logic [3:0]  rdAddrA, rdAddrB, wrAddr, usrAddr;
  logic [31:0] wrData, usrWData, spsrWData;
  logic [31:0] rdDataA, rdDataB, usrRData, spsrRData, statusOut;
  logic        spsrIllegal, modeErr;

  always #2.5 clk = ~clk;

  rbank_top u_dut (
    .clk(clk), .rstN(rstN), .bootReq(bootReq), .modeChgReq(modeChgReq), .modeIn(modeIn),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .usrAddr(usrAddr), .usrWe(usrWe), .usrWData(usrWData), .usrRData(usrRData),
    .spsrRdEn(spsrRdEn), .spsrWe(spsrWe), .spsrWData(spsrWData), .spsrRData(spsrRData),
    .spsrIllegal(spsrIllegal), .statusOut(statusOut), .modeErr(modeErr)
  );

  int checks = 0;
  int errors = 0;

  // bench model
  logic [31:0] mLow [8];
  logic [31:0] mHi  [2][5];
  logic [31:0] mSp  [6];
  logic [31:0] mLr  [6];
  logic [31:0] mPc;
  logic [31:0] mSav [5];
  logic [31:0] mStat;

  logic [4:0] modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic int grpB(input logic [4:0] m);
    case (m)
      5'b10000, 5'b11111: return 0;
      5'b10011: return 1;
      5'b10111: return 2;
      5'b11011: return 3;
      5'b10010: return 4;
      5'b10001: return 5;
      default:  return -1;
    endcase
  endfunction

  function automatic bit curFiq();
    return mStat[4:0] == 5'b10001;
  endfunction

  function automatic int curGrp();
    return grpB(mStat[4:0]);
  endfunction

  function automatic logic [31:0] expRd(input int a, input bit f, input int g);
    if (a < 8)       return mLow[a];
    else if (a < 13) return mHi[f ? 1 : 0][a - 8];
    else if (a == 13) return mSp[g];
    else if (a == 14) return mLr[g];
    else             return mPc;
  endfunction

  function automatic string tagOf(input int a);
    if (a < 8 || a == 15) return "R6";
    else if (a < 13)      return "R5";
    else                  return "R4";
  endfunction

  task automatic mdlWr(input int a, input logic [31:0] d, input bit f, input int g);
    if (a < 8)        mLow[a] = d;
    else if (a < 13)  mHi[f ? 1 : 0][a - 8] = d;
    else if (a == 13) mSp[g] = d;
    else if (a == 14) mLr[g] = d;
    else              mPc = d;
  endtask

  task automatic mdlClear();
    for (int i = 0; i < 8; i++) mLow[i] = '0;
    for (int c = 0; c < 2; c++) for (int j = 0; j < 5; j++) mHi[c][j] = '0;
    for (int g = 0; g < 6; g++) begin mSp[g] = '0; mLr[g] = '0; end
    for (int k = 0; k < 5; k++) mSav[k] = '0;
    mPc = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic goMode(input logic [4:0] m);
    modeIn = m; modeChgReq = 1'b1;
    tick();
    modeChgReq = 1'b0;
    if (grpB(m) >= 0) mStat[4:0] = m;
  endtask

  task automatic liveWr(input int a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = d;
    tick();
    wrEn = 1'b0;
    mdlWr(a, d, curFiq(), curGrp());
  endtask

  task automatic usrWr(input int a, input logic [31:0] d);
    usrWe = 1'b1; usrAddr = 4'(a); usrWData = d;
    tick();
    usrWe = 1'b0;
    mdlWr(a, d, 1'b0, 0);
  endtask

  task automatic chkLive();
    for (int a = 0; a < 16; a++) begin
      rdAddrA = 4'(a); rdAddrB = 4'(15 - a);
      #0.25;
      chk(tagOf(a), rdDataA, expRd(a, curFiq(), curGrp()));
      chk("R11", rdDataB, expRd(15 - a, curFiq(), curGrp()));
    end
  endtask

  task automatic chkSaved();
    int g;
    g = curGrp();
    spsrRdEn = 1'b1;
    #0.25;
    chk("R7", spsrRData, (g > 0) ? mSav[g - 1] : 32'h0);
    chk("R7", {31'h0, spsrIllegal}, (g == 0) ? 32'h1 : 32'h0);
    spsrRdEn = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; bootReq = 1'b0; modeChgReq = 1'b0; modeIn = '0;
    rdAddrA = '0; rdAddrB = '0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    usrAddr = '0; usrWe = 1'b0; usrWData = '0; spsrRdEn = 1'b0; spsrWe = 1'b0; spsrWData = '0;
    mdlClear();
    mStat = 32'h0000_0013;
    tick(); tick(); tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1", statusOut, 32'h0000_0013);
    chkLive();
    chkSaved();
    for (int mi = 0; mi < 7; mi++) begin
      goMode(modes[mi]);
      rdAddrA = 4'd13; #0.25;
      chk("R1", rdDataA, 32'h0);
    end

    // fill every copy in every mode
    for (int mi = 0; mi < 7; mi++) begin
      goMode(modes[mi]);
      chk("R2", statusOut, mStat);
      chk("R3", {31'h0, modeErr}, 32'h0);
      for (int a = 0; a < 16; a++)
        liveWr(a, {8'(mi + 1), 8'(a), 16'hC0DE});
      spsrWe = 1'b1; spsrWData = {8'hE0, 8'(mi), 16'h5A5A};
      tick();
      spsrWe = 1'b0;
      if (curGrp() > 0) mSav[curGrp() - 1] = spsrWData;
    end

    // read back in every mode (R4 R5 R6 R7)
    for (int mi = 0; mi < 7; mi++) begin
      goMode(modes[mi]);
      chkLive();
      chkSaved();
    end

    // user-bank port (R8)
    for (int mi = 0; mi < 7; mi++) begin
      goMode(modes[mi]);
      for (int a = 8; a < 15; a++) usrWr(a, {8'hB0, 8'(mi), 8'(a), 8'h11});
      for (int a = 0; a < 16; a++) begin
        usrAddr = 4'(a); #0.25;
        chk("R8", usrRData, expRd(a, 1'b0, 0));
      end
      chkLive();
    end

    // unknown encodings (R3)
    goMode(5'b10010);
    for (int e = 0; e < 32; e++) begin
      if (grpB(5'(e)) < 0) begin
        logic [31:0] prev;
        prev = statusOut;
        goMode(5'(e));
        chk("R3", {31'h0, modeErr}, 32'h1);
        chk("R3", statusOut, prev);
        tick();
        chk("R3", {31'h0, modeErr}, 32'h0);
      end
    end
    chkLive();

    // same-cycle conflicts (R10)
    goMode(5'b10011);
    wrEn = 1'b1; wrAddr = 4'd13; wrData = 32'h1234_5678;
    modeIn = 5'b10010; modeChgReq = 1'b1;
    tick();
    wrEn = 1'b0; modeChgReq = 1'b0;
    mdlWr(13, 32'h1234_5678, 1'b0, 1);
    mStat[4:0] = 5'b10010;
    chk("R10", statusOut, mStat);
    chkLive();
    goMode(5'b10011);
    rdAddrA = 4'd13; #0.25;
    chk("R10", rdDataA, 32'h1234_5678);

    goMode(5'b10000);
    wrEn = 1'b1; wrAddr = 4'd13; wrData = 32'hAAAA_0001;
    usrWe = 1'b1; usrAddr = 4'd13; usrWData = 32'hBBBB_0002;
    tick();
    wrEn = 1'b0; usrWe = 1'b0;
    mSp[0] = 32'hBBBB_0002;
    rdAddrA = 4'd13; #0.25;
    chk("R10", rdDataA, 32'hBBBB_0002);

    // fast boot (R9), boot beats write and mode change (R10)
    bootReq = 1'b1; wrEn = 1'b1; wrAddr = 4'd0; wrData = 32'hDEAD_BEEF;
    modeIn = 5'b10001; modeChgReq = 1'b1;
    tick();
    bootReq = 1'b0; wrEn = 1'b0; modeChgReq = 1'b0;
    mdlClear();
    mLow[0] = 32'h0800_0000; mLow[1] = 32'h0000_00EA;
    mSp[0] = 32'h0300_7F00; mSp[4] = 32'h0300_7FA0; mSp[1] = 32'h0300_7FE0;
    mPc = 32'h0800_0000;
    mStat = 32'h6000_001F;
    chk("R9", statusOut, 32'h6000_001F);
    rdAddrA = 4'd0; #0.25;
    chk("R10", rdDataA, 32'h0800_0000);
    chkLive();
    chkSaved();
    goMode(5'b10010);
    chkLive();
    rdAddrA = 4'd13; #0.25;
    chk("R9", rdDataA, 32'h0300_7FA0);
    goMode(5'b10011);
    chkLive();
    chkSaved();
    goMode(5'b10001);
    chkLive();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule